// File: doc/BRIEF.md
# Half-Rate Two-Tap Decision Feedback Slicer

This block turns quantized received samples into bit decisions and removes the trailing inter-symbol interference of the two previous bits. It works at half rate: every clock it takes one sample per lane, two lanes by default, where lane 0 carries the earlier bit of the pair. Each lane resolves its own bit in the same clock. The previous-bit correction therefore crosses between lanes. A lane uses the bit its neighbour is deciding in the same cycle, or the registered bits from the cycle before.

The first tap is subtracted from the data side. The second tap sits on the reference side with its sign reversed. A signed offset on the reference side moves the slicing threshold, so an eye scan can sweep it across the opening. The weights and the offset are static codes that are set before use. The decisions are registered.

Top module: `dfe_hr2`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dec` becomes all zeros and the stored past decisions are cleared to 0. Lane 0's first decision after reset sees two past bits of 0.
- R2: The decision for the samples presented in one cycle appears on `dec` after the next rising edge. `dec[i]` belongs to lane i.
- R3: A 6-bit weight code gives a magnitude of (c[0]+c[3])·1 + (c[1]+c[4])·2 + (c[2]+c[5])·4, which lies in 0..14. This magnitude is multiplied by 2^TAP_SHIFT.
- R4: `ofs_code` is a 6-bit two's-complement value from −32 to 31. It is multiplied by 2^OFS_SHIFT and added to the reference term.
- R5: A lane decides 1 exactly when sample − s1·W1 ≥ s2·W2 + OFS. Here s is +1 for a past bit of 1 and −1 for a past bit of 0. s1 is the bit one position earlier and s2 is the bit two positions earlier.
- R6: When both sides of the comparison are equal (zero margin), the decision is 1.
- R7: Lane 0 takes its one-bit-earlier decision from the last lane's decision of the previous cycle. It takes its two-bit-earlier decision from the next-to-last lane's decision of the previous cycle.
- R8: A lane i > 0 takes its one-bit-earlier decision from lane i−1 in the same cycle. Its two-bit-earlier decision is lane i−2 in the same cycle, or the last lane of the previous cycle when i = 1.
- R9: No sum overflows. Full-scale samples with the largest weights and offsets still decide by the exact signed comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one rising edge per lane group |
| rst | input | 1 | Synchronous active-high reset |
| rx_samples | input | LANES*SAMPLE_W | Signed samples, lane 0 in the low bits |
| w1_code | input | 6 | Weight code of the one-bit-earlier tap |
| w2_code | input | 6 | Weight code of the two-bit-earlier tap |
| ofs_code | input | 6 | Signed threshold offset code |
| dec | output | LANES | Registered decisions, lane 0 earliest |

## Verification
The bench builds the block with its default parameters: two lanes, 8-bit samples, a tap shift of 2 and no offset shift. A single tap can then reach 56 and the offset spans −32 to 31. The weights are therefore large enough to overturn the sign of most small samples. This makes both the cross-lane feedback paths and the reference-side sign of the second tap visible in the decisions. Full-scale samples of −128 and 127 combined with maximum weights push the margin near its widest range. Samples computed for an exact zero margin reach the tie rule.

// File: rtl/dfe_hr2_pkg.sv
package dfe_hr2_pkg;
  localparam int GRP_W  = 3;
  localparam int NGRP   = 2;
  localparam int CODE_W = GRP_W * NGRP;
  localparam int MAG_W  = GRP_W + $clog2(NGRP) + 1;

  // Magnitude of a weight code: each group's bits carry 1,2,4; the groups add.
  function automatic logic [MAG_W-1:0] code_mag(input logic [CODE_W-1:0] code);
    logic [MAG_W-1:0] acc;
    acc = '0;
    for (int g = 0; g < NGRP; g++)
      acc = acc + MAG_W'(code[g*GRP_W +: GRP_W]);
    return acc;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Width holding sample, two taps and the offset without overflow.
  function automatic int margin_width(input int sw, input int tshift, input int oshift);
    return max3(sw, MAG_W + tshift + 1, CODE_W + oshift) + 3;
  endfunction
endpackage

// File: rtl/dfe_hr2_tapw.sv
module dfe_hr2_tapw
  import dfe_hr2_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output logic [MAG_W-1:0]  mag
);
  assign mag = code_mag(code);
endmodule

// File: rtl/dfe_hr2_slicer.sv
module dfe_hr2_slicer
  import dfe_hr2_pkg::*;
#(
  parameter int SAMPLE_W  = 8,
  parameter int TAP_SHIFT = 2,
  parameter int OFS_SHIFT = 0,
  parameter int SUM_W     = 12
) (
  input  logic signed [SAMPLE_W-1:0] sample,
  input  logic                       prev1,
  input  logic                       prev2,
  input  logic [MAG_W-1:0]           w1_mag,
  input  logic [MAG_W-1:0]           w2_mag,
  input  logic [CODE_W-1:0]          ofs_code,
  output logic signed [SUM_W-1:0]    margin,
  output logic                       decision
);
  logic signed [SUM_W-1:0] smp_x, w1_x, w2_x, ofs_x, data_term, ref_term;

  assign smp_x = {{(SUM_W-SAMPLE_W){sample[SAMPLE_W-1]}}, sample};
  assign w1_x  = $signed({{(SUM_W-MAG_W){1'b0}}, w1_mag}) <<< TAP_SHIFT;
  assign w2_x  = $signed({{(SUM_W-MAG_W){1'b0}}, w2_mag}) <<< TAP_SHIFT;
  assign ofs_x = $signed({{(SUM_W-CODE_W){ofs_code[CODE_W-1]}}, ofs_code}) <<< OFS_SHIFT;

  // Tap 1 corrects the data side; tap 2 lives on the reference side, sign flipped.
  assign data_term = prev1 ? (smp_x - w1_x) : (smp_x + w1_x);
  assign ref_term  = (prev2 ? w2_x : -w2_x) + ofs_x;
  assign margin    = data_term - ref_term;
  assign decision  = ~margin[SUM_W-1];
endmodule

// File: rtl/dfe_hr2.sv
module dfe_hr2
  import dfe_hr2_pkg::*;
#(
  parameter int LANES     = 2,
  parameter int SAMPLE_W  = 8,
  parameter int TAP_SHIFT = 2,
  parameter int OFS_SHIFT = 0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [LANES*SAMPLE_W-1:0] rx_samples,
  input  logic [CODE_W-1:0]         w1_code,
  input  logic [CODE_W-1:0]         w2_code,
  input  logic [CODE_W-1:0]         ofs_code,
  output logic [LANES-1:0]          dec
);
  localparam int SUM_W = margin_width(SAMPLE_W, TAP_SHIFT, OFS_SHIFT);

  logic [MAG_W-1:0] w1_mag, w2_mag;
  logic [LANES-1:0] lane_dec;
  logic [LANES-1:0] lane_p1, lane_p2;

  dfe_hr2_tapw u_w1 (.code(w1_code), .mag(w1_mag));
  dfe_hr2_tapw u_w2 (.code(w2_code), .mag(w2_mag));

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic signed [SUM_W-1:0] margin;
    if (i == 0) begin : g_first
      assign lane_p1[i] = dec[LANES-1];
      assign lane_p2[i] = dec[LANES-2];
    end else if (i == 1) begin : g_second
      assign lane_p1[i] = lane_dec[0];
      assign lane_p2[i] = dec[LANES-1];
    end else begin : g_rest
      assign lane_p1[i] = lane_dec[i-1];
      assign lane_p2[i] = lane_dec[i-2];
    end
    dfe_hr2_slicer #(
      .SAMPLE_W(SAMPLE_W), .TAP_SHIFT(TAP_SHIFT),
      .OFS_SHIFT(OFS_SHIFT), .SUM_W(SUM_W)
    ) u_slc (
      .sample  (rx_samples[i*SAMPLE_W +: SAMPLE_W]),
      .prev1   (lane_p1[i]),
      .prev2   (lane_p2[i]),
      .w1_mag  (w1_mag),
      .w2_mag  (w2_mag),
      .ofs_code(ofs_code),
      .margin  (margin),
      .decision(lane_dec[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) dec <= '0;
    else     dec <= lane_dec;
  end
endmodule

// File: rtl/dfe_hr2_checker.sv
module dfe_hr2_checker #(
  parameter int LANES    = 2,
  parameter int SAMPLE_W = 8,
  parameter int CODE_W   = 6
) (
  input logic                      clk,
  input logic                      rst,
  input logic [LANES*SAMPLE_W-1:0] rx_samples,
  input logic [CODE_W-1:0]         w1_code,
  input logic [CODE_W-1:0]         w2_code,
  input logic [CODE_W-1:0]         ofs_code,
  input logic [LANES-1:0]          lane_dec,
  input logic [LANES-1:0]          dec
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> dec == '0);

  assert_one_cycle_R2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> dec == $past(lane_dec));

  assert_plain_sign_R5: assert property (@(posedge clk) disable iff (rst)
    (w1_code == '0 && w2_code == '0 && ofs_code == '0)
    |=> dec[0] == !$past(rx_samples[SAMPLE_W-1]));

  assert_zero_tie_R6: assert property (@(posedge clk) disable iff (rst)
    (rx_samples == '0 && w1_code == '0 && w2_code == '0 && ofs_code == '0)
    |=> dec == '1);

  assert_cross_lane_R8: assert property (@(posedge clk) disable iff (rst)
    (rx_samples == '0 && w1_code != '0 && w2_code == '0 && ofs_code == '0)
    |=> dec[1] != dec[0]);
endmodule

bind dfe_hr2 dfe_hr2_checker #(
  .LANES(LANES), .SAMPLE_W(SAMPLE_W), .CODE_W(dfe_hr2_pkg::CODE_W)
) i_dfe_hr2_checker (
  .clk(clk), .rst(rst), .rx_samples(rx_samples), .w1_code(w1_code),
  .w2_code(w2_code), .ofs_code(ofs_code), .lane_dec(lane_dec), .dec(dec)
);

// File: tb/test_dfe_hr2.sv
module test_dfe_hr2;
  localparam int SW = 8;
  localparam int TSH = 2;
  localparam int OSH = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2*SW-1:0] rx_samples = '0;
  logic [5:0] w1_code = '0, w2_code = '0, ofs_code = '0;
  logic [1:0] dec;

  int checks = 0, failures = 0, cycles = 0;
  bit hb1 = 0, hb2 = 0;  // model history: most recent and one before

  dfe_hr2 #(.LANES(2), .SAMPLE_W(SW), .TAP_SHIFT(TSH), .OFS_SHIFT(OSH)) i_dfe_hr2 (
    .clk(clk), .rst(rst), .rx_samples(rx_samples), .w1_code(w1_code),
    .w2_code(w2_code), .ofs_code(ofs_code), .dec(dec));

  always #5 clk = ~clk;

  function automatic int wval(input int c);
    return ((c % 8) + (c / 8)) * (1 << TSH);
  endfunction

  function automatic int oval(input int c);
    return ((c >= 32) ? c - 64 : c) * (1 << OSH);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Drive one cycle at a falling edge and compare after the following rising edge.
  task automatic step(input int x0, input int x1, input int c1, input int c2,
                      input int co, input bit r, input string tag);
    int xs[2];
    logic [1:0] e;
    xs[0] = x0; xs[1] = x1;
    rst = r;
    rx_samples = {SW'(x1), SW'(x0)};
    w1_code = 6'(c1); w2_code = 6'(c2); ofs_code = 6'(co);
    if (r) begin
      e = 2'b00; hb1 = 0; hb2 = 0;
    end else begin
      for (int k = 0; k < 2; k++) begin
        int s1, s2;
        bit d;
        s1 = hb1 ? 1 : -1;
        s2 = hb2 ? 1 : -1;
        d = (xs[k] - s1 * wval(c1)) >= (s2 * wval(c2) + oval(co));
        e[k] = d;
        hb2 = hb1; hb1 = d;
      end
    end
    @(negedge clk);
    checks++;
    if (dec !== e) begin
      failures++;
      $display("FAIL %s: dec=%b expected=%b", tag, dec, e);
    end
  endtask

  function automatic int rs();
    return int'($urandom_range(0, 255)) - 128;
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 50000) begin
        failures++;
        $display("FAIL watchdog: cycles=%0d expected<=%0d", cycles, 50000);
        finish_run();
      end
    end
  end

  initial begin
    @(negedge clk);
    // R1: reset holds decisions at zero whatever the inputs
    for (int n = 0; n < 4; n++) step(100, 100, 0, 0, 0, 1, "R1");
    // R1: first decisions after reset see past bits of 0 (s=-1): 0+W1 >= -W2 ? 1
    step(-20, 0, 7, 1, 0, 0, "R1");
    // R2/R6: all zero inputs -> tie -> 1 on both lanes, one cycle later
    step(0, 0, 0, 0, 0, 0, "R6");
    step(-1, 5, 0, 0, 0, 0, "R2");
    // R3: sweep every tap-1 code with small samples, no tap 2, no offset
    for (int c = 0; c < 64; c++) step(rs() / 4, rs() / 4, c, 0, 0, 0, "R3");
    // R3: tap-2 codes on the reference side
    for (int c = 0; c < 64; c++) step(rs() / 4, rs() / 4, 0, c, 0, 0, "R3");
    // R4: every offset code against samples near the threshold
    for (int c = 0; c < 64; c++) step(oval(c) + int'($urandom_range(0, 2)) - 1,
                                      rs() / 4, 0, 0, c, 0, "R4");
    // R6: exact zero margin on lane 0, computed from the model history
    for (int n = 0; n < 16; n++) begin
      int c1, c2, co, s1, s2;
      c1 = int'($urandom_range(0, 63)); c2 = int'($urandom_range(0, 63));
      co = int'($urandom_range(0, 63));
      s1 = hb1 ? 1 : -1; s2 = hb2 ? 1 : -1;
      step(s1 * wval(c1) + s2 * wval(c2) + oval(co), rs() / 2, c1, c2, co, 0, "R6");
    end
    // R7: zero samples, strong tap 1 only: lane 0 follows last lane of previous cycle
    for (int n = 0; n < 6; n++) step(0, 0, 63, 0, 0, 0, "R7");
    // R8: zero samples, tap 2 only: history two bits back drives both lanes
    for (int n = 0; n < 6; n++) step(0, 0, 0, 63, 0, 0, "R8");
    for (int n = 0; n < 12; n++) step(rs() / 8, rs() / 8, 45, 27, 0, 0, "R8");
    // R1: reset in the middle of traffic
    step(50, -50, 9, 9, 3, 1, "R1");
    step(-3, 3, 9, 9, 3, 0, "R1");
    // R9: full-scale samples with extreme weights and offsets
    step(-128, 127, 63, 63, 31, 0, "R9");
    step(127, -128, 63, 63, 32, 0, "R9");
    step(-128, -128, 63, 63, 32, 0, "R9");
    step(127, 127, 63, 63, 31, 0, "R9");
    for (int n = 0; n < 20; n++)
      step((n % 2) ? 127 : -128, (n % 3) ? -128 : 127, 63, 63,
           (n % 2) ? 31 : 32, 0, "R9");
    // R5: general random traffic
    for (int n = 0; n < 400; n++)
      step(rs(), rs(), int'($urandom_range(0, 63)), int'($urandom_range(0, 63)),
           int'($urandom_range(0, 63)), 0, "R5");
    finish_run();
  end
endmodule